// File: doc/BRIEF.md
# Processor Status Bus Command Generator

This block sits beside a processor that announces each bus cycle with a three-bit, active-low status code. It samples that code on the rising clock edge and produces the strobes the rest of the system needs. These are memory and I/O read and write commands, early ("advanced") write strobes, an interrupt-acknowledge strobe, and the bus-control outputs: address latch enable, data direction and data-buffer enable. It also drives one dual-purpose enable output.

Three mode inputs decide what may reach the bus. `cmd_en` is a global command enable. `iobus_sel` picks between two modes. In shared system-bus mode, an arbiter grants the bus through the active-low `addr_en_n`. In private I/O-bus mode, `addr_en_n` is not consulted. The dual-purpose output `aux_en` follows the mode. In I/O-bus mode it is a peripheral data enable that covers I/O cycles. In system-bus mode it is a cascade enable that is raised while an interrupt-acknowledge cycle starts.

Status encoding (`stat_n`): 000 interrupt acknowledge, 001 I/O read, 010 I/O write, 011 halt, 100 code fetch, 101 memory read, 110 memory write, 111 passive. A cycle begins on the edge that first samples a non-passive code, which is phase T1. It advances to T2 and then T3, and stays in T3 while the code remains non-passive. It ends on the edge that samples passive.

Top module: `pscg_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to idle. In idle, all active-low command outputs are 1, `ale`, `data_en` and `aux_en` are 0, and `dir_tx` is 1.
- R2: Codes 100 and 101 drive `mem_rd_n` low. Code 001 drives `io_rd_n` low. Each is low during T2 and every following T3 of its cycle.
- R3: `ale` is 1 for exactly the one clock of T1 of every non-passive cycle, including halt.
- R4: Code 000 drives `inta_n` low during T2 and T3, and no read command is driven in that cycle.
- R5: Code 110 drives `adv_mem_wr_n` low and code 010 drives `adv_io_wr_n` low, from T2 onward. The matching normal write (`mem_wr_n` or `io_wr_n`) goes low one clock later, in T3 only.
- R6: Code 011 (halt) and 111 (passive) never drive any command output low. Every command returns to 1 on the edge that samples 111.
- R7: `dir_tx` is 0 throughout T1 to T3 of read, fetch and interrupt-acknowledge cycles, and 1 at all other times.
- R8: The buffer window covers T2 and T3 for read, fetch and interrupt-acknowledge cycles, and T1 to T3 for write cycles. It is empty for halt. `data_en` is 1 only inside this window.
- R9: With `cmd_en` = 0, every command output stays 1 and both `data_en` and `aux_en` stay 0.
- R10: In system-bus mode (`iobus_sel` = 0), commands and `data_en` are active only while `addr_en_n` = 0.
- R11: In I/O-bus mode (`cmd_en` = 1 and `iobus_sel` = 1), `addr_en_n` has no effect. `aux_en` gives the buffer window for I/O read and I/O write cycles, and `data_en` gives it for all other cycles.
- R12: In system-bus mode, `aux_en` is 1 only in T1 of an interrupt-acknowledge cycle, and only while `cmd_en` = 1 and `addr_en_n` = 0.
- R13: A status held non-passive beyond T3 (wait states) keeps the T3 outputs unchanged until the edge that samples passive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; status sampled on rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| stat_n | input | 3 | Active-low bus-cycle status code |
| addr_en_n | input | 1 | Active-low bus grant from the arbiter (system-bus mode) |
| cmd_en | input | 1 | Command enable |
| iobus_sel | input | 1 | 1 selects I/O-bus mode, 0 selects system-bus mode |
| mem_rd_n | output | 1 | Memory read command, active low |
| mem_wr_n | output | 1 | Memory write command, active low |
| io_rd_n | output | 1 | I/O read command, active low |
| io_wr_n | output | 1 | I/O write command, active low |
| adv_mem_wr_n | output | 1 | Early memory write command, active low |
| adv_io_wr_n | output | 1 | Early I/O write command, active low |
| inta_n | output | 1 | Interrupt acknowledge strobe, active low |
| ale | output | 1 | Address latch enable |
| dir_tx | output | 1 | Data direction: 1 transmit, 0 receive |
| data_en | output | 1 | Data buffer enable, active high |
| aux_en | output | 1 | Peripheral enable (I/O-bus mode) or cascade enable (system-bus mode) |

## Verification
The bench walks every status code through T1, T2 and T3 and checks each output in each phase. A design that raised the normal write with the advanced write, or held `ale` for two clocks, would miss one of those phase checks. Wait-state cycles check that T3 outputs hold, and an early return to passive checks that commands drop on that edge. Mode tests lift `addr_en_n` in each mode and clear `cmd_en`. They also compare `aux_en` in both of its personalities, so a design that gated I/O-bus commands by the arbiter, or left the buffer enables alive with commands disabled, shows a wrong strobe.

// File: rtl/pscg_pkg.sv
// Shared types for the status bus command generator.
// Assumes a three-bit active-low status code with 111 meaning passive.
package pscg_pkg;
    localparam int STAT_W = 3;
    localparam logic [STAT_W-1:0] STAT_PASSIVE = '1;

    typedef enum logic [1:0] {PH_IDLE, PH_T1, PH_T2, PH_T3} phase_e;
    typedef enum logic [2:0] {CK_INTA, CK_IORD, CK_IOWR, CK_HALT,
                              CK_MRD, CK_MWR, CK_NONE} cyc_e;

    // Map a raw status code to the kind of bus cycle it announces.
    function automatic cyc_e decode_stat(input logic [STAT_W-1:0] s);
        case (s)
            3'b000:          return CK_INTA;
            3'b001:          return CK_IORD;
            3'b010:          return CK_IOWR;
            3'b011:          return CK_HALT;
            3'b100, 3'b101:  return CK_MRD;
            3'b110:          return CK_MWR;
            default:         return CK_NONE;
        endcase
    endfunction
endpackage

// File: rtl/pscg_seq.sv
// Bus-cycle sequencer: tracks T1/T2/T3 from the status code and latches
// the cycle kind at T1. Assumes the status is stable around each edge.
module pscg_seq
    import pscg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] stat_n,
    output phase_e            phase,
    output cyc_e              kind
);
    logic passive;
    assign passive = (stat_n == STAT_PASSIVE);

    // Advance the phase each edge; a passive sample always ends the cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            kind  <= CK_NONE;
        end else if (passive) begin
            phase <= PH_IDLE;
            kind  <= CK_NONE;
        end else begin
            case (phase)
                PH_IDLE: begin
                    phase <= PH_T1;
                    kind  <= decode_stat(stat_n);
                end
                PH_T1:   phase <= PH_T2;
                default: phase <= PH_T3;
            endcase
        end
    end

    // R6
    passive_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        passive |=> (phase == PH_IDLE));
    // R3
    t1_follows_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_T1) |=> (phase == PH_T2 || phase == PH_IDLE));
    // R13
    wait_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_T3 && !passive) |=> (phase == PH_T3 && $stable(kind)));
endmodule

// File: rtl/pscg_mode_gate.sv
// Mode gating: derives the command and buffer permissions from the
// command enable, the bus-mode select and the arbiter grant.
module pscg_mode_gate (
    input  logic cmd_en,
    input  logic iobus_sel,
    input  logic addr_en_n,
    output logic io_mode,
    output logic sys_grant,
    output logic cmd_ok
);
    // Combine the three mode inputs into permissions.
    always_comb begin
        io_mode   = cmd_en & iobus_sel;
        sys_grant = cmd_en & ~iobus_sel & ~addr_en_n;
        cmd_ok    = io_mode | sys_grant;
    end
endmodule

// File: rtl/pscg_cmd_out.sv
// Output stage: turns phase, cycle kind and mode permissions into the
// command strobes and bus-control outputs. Purely combinational from the
// sequencer state and the mode inputs.
module pscg_cmd_out
    import pscg_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  phase_e phase,
    input  cyc_e   kind,
    input  logic   io_mode,
    input  logic   sys_grant,
    input  logic   cmd_ok,
    output logic   mem_rd_n,
    output logic   mem_wr_n,
    output logic   io_rd_n,
    output logic   io_wr_n,
    output logic   adv_mem_wr_n,
    output logic   adv_io_wr_n,
    output logic   inta_n,
    output logic   ale,
    output logic   dir_tx,
    output logic   data_en,
    output logic   aux_en
);
    logic in_cycle, late, is_rd, is_wr, is_io, window;

    // Classify the current cycle and its buffer window.
    always_comb begin
        in_cycle = (phase != PH_IDLE);
        late     = (phase == PH_T2) || (phase == PH_T3);
        is_rd    = (kind == CK_MRD) || (kind == CK_IORD) || (kind == CK_INTA);
        is_wr    = (kind == CK_MWR) || (kind == CK_IOWR);
        is_io    = (kind == CK_IORD) || (kind == CK_IOWR);
        window   = (is_rd && late) || (is_wr && in_cycle);
    end

    // Drive the command strobes under the mode permission.
    always_comb begin
        mem_rd_n     = !(cmd_ok && late && kind == CK_MRD);
        io_rd_n      = !(cmd_ok && late && kind == CK_IORD);
        inta_n       = !(cmd_ok && late && kind == CK_INTA);
        adv_mem_wr_n = !(cmd_ok && late && kind == CK_MWR);
        adv_io_wr_n  = !(cmd_ok && late && kind == CK_IOWR);
        mem_wr_n     = !(cmd_ok && phase == PH_T3 && kind == CK_MWR);
        io_wr_n      = !(cmd_ok && phase == PH_T3 && kind == CK_IOWR);
    end

    // Drive the bus-control outputs and the dual-purpose enable.
    always_comb begin
        ale     = (phase == PH_T1);
        dir_tx  = !(in_cycle && is_rd);
        data_en = window && (io_mode ? !is_io : sys_grant);
        aux_en  = io_mode ? (window && is_io)
                          : (sys_grant && phase == PH_T1 && kind == CK_INTA);
    end

    // R3
    ale_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);
    // R5
    adv_covers_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_wr_n |-> !adv_mem_wr_n) and (!io_wr_n |-> !adv_io_wr_n));
    // R4
    one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({~mem_rd_n, ~io_rd_n, ~inta_n, ~adv_mem_wr_n, ~adv_io_wr_n}));
    // R9
    cmd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_ok |-> (mem_rd_n && io_rd_n && inta_n && adv_mem_wr_n && adv_io_wr_n));
    // R7
    dir_rx_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_rd_n || !io_rd_n || !inta_n) |-> !dir_tx);
endmodule

// File: rtl/pscg_top.sv
// Processor status bus command generator top: sequencer, mode gate and
// output stage. Assumes status and mode inputs change away from the
// rising clock edge.
module pscg_top
    import pscg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] stat_n,
    input  logic              addr_en_n,
    input  logic              cmd_en,
    input  logic              iobus_sel,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    output logic              io_rd_n,
    output logic              io_wr_n,
    output logic              adv_mem_wr_n,
    output logic              adv_io_wr_n,
    output logic              inta_n,
    output logic              ale,
    output logic              dir_tx,
    output logic              data_en,
    output logic              aux_en
);
    phase_e phase;
    cyc_e   kind;
    logic   io_mode, sys_grant, cmd_ok;

    pscg_seq u_seq (
        .clk(clk), .rst_n(rst_n), .stat_n(stat_n), .phase(phase), .kind(kind)
    );

    pscg_mode_gate u_gate (
        .cmd_en(cmd_en), .iobus_sel(iobus_sel), .addr_en_n(addr_en_n),
        .io_mode(io_mode), .sys_grant(sys_grant), .cmd_ok(cmd_ok)
    );

    pscg_cmd_out u_out (
        .clk(clk), .rst_n(rst_n), .phase(phase), .kind(kind),
        .io_mode(io_mode), .sys_grant(sys_grant), .cmd_ok(cmd_ok),
        .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .io_rd_n(io_rd_n),
        .io_wr_n(io_wr_n), .adv_mem_wr_n(adv_mem_wr_n), .adv_io_wr_n(adv_io_wr_n),
        .inta_n(inta_n), .ale(ale), .dir_tx(dir_tx), .data_en(data_en),
        .aux_en(aux_en)
    );

    // R12
    cascade_t1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_en && !iobus_sel) |-> (ale && !addr_en_n && cmd_en));
    // R10
    sys_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!iobus_sel && addr_en_n) |-> (!data_en && mem_rd_n && mem_wr_n
                                       && io_rd_n && io_wr_n && inta_n));
endmodule

// File: tb/pscg_top_bench.sv
// Directed bench: one task per scenario, outputs sampled on the falling edge.
module pscg_top_bench;
    localparam time CLK_PERIOD = 10;

    logic clk = 0, rst_n = 0;
    logic [2:0] stat_n = 3'b111;
    logic addr_en_n = 0, cmd_en = 1, iobus_sel = 0;
    logic mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, adv_mem_wr_n, adv_io_wr_n;
    logic inta_n, ale, dir_tx, data_en, aux_en;
    int n_run = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pscg_top u_pscg_top (
        .clk(clk), .rst_n(rst_n), .stat_n(stat_n), .addr_en_n(addr_en_n),
        .cmd_en(cmd_en), .iobus_sel(iobus_sel), .mem_rd_n(mem_rd_n),
        .mem_wr_n(mem_wr_n), .io_rd_n(io_rd_n), .io_wr_n(io_wr_n),
        .adv_mem_wr_n(adv_mem_wr_n), .adv_io_wr_n(adv_io_wr_n),
        .inta_n(inta_n), .ale(ale), .dir_tx(dir_tx), .data_en(data_en),
        .aux_en(aux_en)
    );

    task automatic chk(input string tag, input string sig, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, sig, act, exp, $time);
        end
    endtask

    // Compare every output with the requirement model for phase ph (0 idle).
    task automatic check_all(input string tag, input logic [2:0] code, input int ph);
        logic rd, wr, io, win, late, gate, iom, sysg;
        late = (ph == 2 || ph == 3);
        rd   = (code == 3'b000 || code == 3'b001 || code == 3'b100 || code == 3'b101) && ph != 0;
        wr   = (code == 3'b010 || code == 3'b110) && ph != 0;
        io   = (code == 3'b001 || code == 3'b010);
        win  = (rd && late) || wr;
        iom  = cmd_en && iobus_sel;
        sysg = cmd_en && !iobus_sel && !addr_en_n;
        gate = iom || sysg;
        chk({tag, "/R2"}, "mem_rd_n", mem_rd_n, !(gate && late && (code == 3'b100 || code == 3'b101)));
        chk({tag, "/R2"}, "io_rd_n", io_rd_n, !(gate && late && code == 3'b001));
        chk({tag, "/R4"}, "inta_n", inta_n, !(gate && late && code == 3'b000));
        chk({tag, "/R5"}, "adv_mem_wr_n", adv_mem_wr_n, !(gate && late && code == 3'b110));
        chk({tag, "/R5"}, "adv_io_wr_n", adv_io_wr_n, !(gate && late && code == 3'b010));
        chk({tag, "/R5"}, "mem_wr_n", mem_wr_n, !(gate && ph == 3 && code == 3'b110));
        chk({tag, "/R5"}, "io_wr_n", io_wr_n, !(gate && ph == 3 && code == 3'b010));
        chk({tag, "/R3"}, "ale", ale, ph == 1);
        chk({tag, "/R7"}, "dir_tx", dir_tx, !rd);
        chk({tag, "/R8"}, "data_en", data_en, win && (iom ? !io : sysg));
        chk({tag, "/R11"}, "aux_en", aux_en,
            iom ? (win && io) : (sysg && ph == 1 && code == 3'b000));
    endtask

    // Run one bus cycle of code with nwait extra T3 clocks, checking each phase.
    task automatic run_cycle(input string tag, input logic [2:0] code, input int nwait);
        @(negedge clk) stat_n = code;
        @(negedge clk) check_all(tag, code, 1);
        @(negedge clk) check_all(tag, code, 2);
        for (int i = 0; i <= nwait; i++) begin
            @(negedge clk) check_all(tag, code, 3);
        end
        stat_n = 3'b111;
        @(negedge clk) check_all({tag, "/R6"}, code, 0);
    endtask

    task automatic t_reset();
        rst_n = 0;
        repeat (2) @(negedge clk);
        check_all("R1", 3'b111, 0);
        rst_n = 1;
        @(negedge clk) check_all("R1", 3'b111, 0);
    endtask

    task automatic t_all_codes();
        for (int c = 0; c < 7; c++) run_cycle("R2", 3'(c), 0);
    endtask

    task automatic t_halt_passive();
        run_cycle("R6", 3'b011, 1);
        @(negedge clk) check_all("R6", 3'b111, 0);
    endtask

    task automatic t_wait_states();
        run_cycle("R13", 3'b101, 3);
        run_cycle("R13", 3'b110, 2);
    endtask

    task automatic t_early_end();
        // Status goes passive right after T1: everything drops on that edge.
        @(negedge clk) stat_n = 3'b110;
        @(negedge clk) check_all("R5", 3'b110, 1);
        stat_n = 3'b111;
        @(negedge clk) check_all("R6", 3'b110, 0);
    endtask

    task automatic t_cmd_off();
        cmd_en = 0;
        run_cycle("R9", 3'b101, 0);
        run_cycle("R9", 3'b010, 0);
        iobus_sel = 1;
        run_cycle("R9", 3'b001, 0);
        iobus_sel = 0;
        cmd_en = 1;
    endtask

    task automatic t_sysbus();
        addr_en_n = 1;
        run_cycle("R10", 3'b101, 0);
        run_cycle("R10", 3'b000, 0);
        addr_en_n = 0;
        run_cycle("R10", 3'b110, 0);
    endtask

    task automatic t_iobus();
        iobus_sel = 1;
        addr_en_n = 1;
        run_cycle("R11", 3'b001, 0);
        run_cycle("R11", 3'b010, 1);
        run_cycle("R11", 3'b101, 0);
        run_cycle("R11", 3'b000, 0);
        addr_en_n = 0;
        run_cycle("R11", 3'b110, 0);
        iobus_sel = 0;
    endtask

    task automatic t_cascade();
        run_cycle("R12", 3'b000, 0);
        run_cycle("R12", 3'b001, 0);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 20000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_all_codes();
        t_halt_passive();
        t_wait_states();
        t_early_end();
        t_cmd_off();
        t_sysbus();
        t_iobus();
        t_cascade();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule